// File: doc/BRIEF.md
# Speculative Load Conflict Tracker

This block supports compile-time hoisting of loads above earlier stores. When a hoisted (speculative) load issues, the pipeline writes the load's word address and destination register tag into a small associative table. Every later store compares its word address against all live entries in parallel. A match flags the entry as conflicted.

At the load's original program position, a check operation looks the entry up by register tag. One cycle later the block reports whether the hoisted value can be kept or the load must be replayed. A check consumes the entry it finds. A check that finds nothing reports a replay, because the block cannot prove that no conflict occurred.

The table holds `ENTRIES` slots. An insert first reuses a slot that already holds the same tag, then takes the lowest free slot, and otherwise evicts in round-robin order. Replaying the load and the memory system lie outside the block.

Top module: `spec_load_tracker`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `chk_done` is 0. After reset the table is empty, so a check on any tag reports `chk_replay` = 1.
- R2: `chk_done` is 1 in exactly the cycle after a cycle with `chk_valid` = 1, and 0 otherwise. `chk_replay` is 0 whenever `chk_done` is 0.
- R3: A check on a tag whose entry saw no conflicting store since its insert reports `chk_replay` = 0.
- R4: Addresses are byte addresses compared at word granularity: bits [ADDR_W-1:2] for 4-byte words. A store in a cycle after an entry's insert, with the same word address and any byte offset, makes a later check of that entry report `chk_replay` = 1.
- R5: A store to a different word address has no effect on an entry.
- R6: A check invalidates the entry it finds. A second check of the same tag with no insert in between reports `chk_replay` = 1.
- R7: A check on a tag with no valid entry reports `chk_replay` = 1.
- R8: An insert of a tag not present in the table goes to the lowest-numbered free slot. If all slots are valid, it replaces the slot at a round-robin pointer. The pointer is 0 after reset and advances by one, wrapping at `ENTRIES`, on each such replacement only. A check of the replaced tag then reports `chk_replay` = 1.
- R9: A store and an insert in the same cycle to the same word do not mark the new entry.
- R10: An insert of a tag already present overwrites that entry's address and clears its conflict flag, without using another slot. At most one valid entry matches any tag.
- R11: A check uses the table state from before the same cycle's store and insert. A store in the check's cycle does not change its result. An insert of the checked tag in that cycle survives the check as a fresh entry.
- R12: One store marks every valid entry whose word address matches it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Insert a speculative load this cycle |
| ins_tag | input | TAG_W | Destination register tag of the load |
| ins_addr | input | ADDR_W | Byte address of the load |
| st_valid | input | 1 | A store is snooped this cycle |
| st_addr | input | ADDR_W | Byte address of the store |
| chk_valid | input | 1 | Check request this cycle |
| chk_tag | input | TAG_W | Register tag to check |
| chk_done | output | 1 | Check result valid (one cycle after request) |
| chk_replay | output | 1 | 1 = load must be re-executed |

## Verification
Random traffic draws tags from a range larger than the table, so reuse, free-slot fills and round-robin evictions all occur. Store addresses come from a small word pool with random byte offsets, so same-word hits at other offsets are told apart from neighbouring-word misses. Directed cases cover the following:
- simultaneous insert and store to one word, which separates insert-first ordering from store-first;
- a check in the same cycle as a store or a re-insert, which shows that the check reads the state from before that cycle;
- two loads to one word, which shows that a store marks every match and not only the first;
- a fill-then-evict sequence, which separates lowest-free placement from pointer placement and shows the pointer advancing.

// File: rtl/sltrk_pkg.sv
package sltrk_pkg;

    // How the allocator picked the slot for an insert
    typedef enum logic [1:0] {
        SLOT_REUSE = 2'd0,   // same tag already resident
        SLOT_FREE  = 2'd1,   // lowest invalid slot
        SLOT_EVICT = 2'd2    // table full, round-robin victim
    } slot_kind_e;

    // Registered check result
    typedef struct packed {
        logic done;
        logic replay;
    } chk_resp_t;

    // Next round-robin pointer value with wrap at the entry count
    function automatic int unsigned rr_next(input int unsigned cur, input int unsigned count);
        return (cur + 1 >= count) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/sltrk_entry.sv
module sltrk_entry #(
    parameter int TAG_W  = 5,
    parameter int WORD_W = 30
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              clr_en,
    input  logic              st_valid,
    input  logic [WORD_W-1:0] st_word,
    output logic              valid_o,
    output logic              viol_o,
    output logic [TAG_W-1:0]  tag_o,
    output logic [WORD_W-1:0] word_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            viol_o  <= 1'b0;
            tag_o   <= '0;
            word_o  <= '0;
        end else if (wr_en) begin
            // insert wins over same-cycle store and check
            valid_o <= 1'b1;
            viol_o  <= 1'b0;
            tag_o   <= wr_tag;
            word_o  <= wr_word;
        end else begin
            if (clr_en)
                valid_o <= 1'b0;
            if (st_valid && valid_o && (st_word == word_o))
                viol_o <= 1'b1;
        end
    end
endmodule

// File: rtl/sltrk_alloc.sv
module sltrk_alloc
    import sltrk_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int TAG_W   = 5,
    parameter int IDX_W   = 3
) (
    input  logic [ENTRIES-1:0] valid_i,
    input  logic [TAG_W-1:0]   tag_i [ENTRIES],
    input  logic [TAG_W-1:0]   ins_tag_i,
    input  logic [IDX_W-1:0]   rr_ptr_i,
    output logic [IDX_W-1:0]   slot_o,
    output slot_kind_e         kind_o
);
    logic             free_found, tag_found;
    logic [IDX_W-1:0] free_idx, tag_idx;

    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        tag_found  = 1'b0;
        tag_idx    = '0;
        // descending scan so the lowest index is kept last
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_i[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
            if (valid_i[i] && (tag_i[i] == ins_tag_i)) begin
                tag_found = 1'b1;
                tag_idx   = IDX_W'(i);
            end
        end
        if (tag_found) begin
            kind_o = SLOT_REUSE;
            slot_o = tag_idx;
        end else if (free_found) begin
            kind_o = SLOT_FREE;
            slot_o = free_idx;
        end else begin
            kind_o = SLOT_EVICT;
            slot_o = rr_ptr_i;
        end
    end
endmodule

// File: rtl/sltrk_lookup.sv
module sltrk_lookup #(
    parameter int ENTRIES = 8,
    parameter int TAG_W   = 5,
    parameter int IDX_W   = 3
) (
    input  logic [ENTRIES-1:0] valid_i,
    input  logic [ENTRIES-1:0] viol_i,
    input  logic [TAG_W-1:0]   tag_i [ENTRIES],
    input  logic [TAG_W-1:0]   chk_tag_i,
    output logic [ENTRIES-1:0] hit_vec_o,
    output logic               hit_o,
    output logic [IDX_W-1:0]   hit_idx_o,
    output logic               hit_viol_o
);
    always_comb begin
        hit_idx_o  = '0;
        hit_viol_o = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            hit_vec_o[i] = valid_i[i] && (tag_i[i] == chk_tag_i);
            if (hit_vec_o[i]) begin
                hit_idx_o  = IDX_W'(i);
                hit_viol_o = viol_i[i];
            end
        end
        hit_o = |hit_vec_o;
    end
endmodule

// File: rtl/spec_load_tracker.sv
module spec_load_tracker
    import sltrk_pkg::*;
#(
    parameter int ENTRIES    = 8,
    parameter int TAG_W      = 5,
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ins_valid,
    input  logic [TAG_W-1:0]  ins_tag,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic              chk_valid,
    input  logic [TAG_W-1:0]  chk_tag,
    output logic              chk_done,
    output logic              chk_replay
);
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int OFS_W  = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 0;
    localparam int WORD_W = ADDR_W - OFS_W;

    logic [ENTRIES-1:0] valid_q, viol_q, hit_vec;
    logic [TAG_W-1:0]   tag_q  [ENTRIES];
    logic [WORD_W-1:0]  word_q [ENTRIES];

    logic [WORD_W-1:0]  ins_word, st_word;
    logic [IDX_W-1:0]   rr_ptr_q, alloc_slot, hit_idx;
    slot_kind_e         alloc_kind;
    logic               hit, hit_viol;
    chk_resp_t          resp_q;

    assign ins_word = ins_addr[ADDR_W-1:OFS_W];
    assign st_word  = st_addr[ADDR_W-1:OFS_W];

    sltrk_alloc #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_alloc (
        .valid_i   (valid_q),
        .tag_i     (tag_q),
        .ins_tag_i (ins_tag),
        .rr_ptr_i  (rr_ptr_q),
        .slot_o    (alloc_slot),
        .kind_o    (alloc_kind)
    );

    sltrk_lookup #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_lookup (
        .valid_i    (valid_q),
        .viol_i     (viol_q),
        .tag_i      (tag_q),
        .chk_tag_i  (chk_tag),
        .hit_vec_o  (hit_vec),
        .hit_o      (hit),
        .hit_idx_o  (hit_idx),
        .hit_viol_o (hit_viol)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        logic wr_en_g, clr_en_g;
        assign wr_en_g  = ins_valid && (alloc_slot == IDX_W'(g));
        assign clr_en_g = chk_valid && hit && (hit_idx == IDX_W'(g));

        sltrk_entry #(.TAG_W(TAG_W), .WORD_W(WORD_W)) u_entry (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (wr_en_g),
            .wr_tag   (ins_tag),
            .wr_word  (ins_word),
            .clr_en   (clr_en_g),
            .st_valid (st_valid),
            .st_word  (st_word),
            .valid_o  (valid_q[g]),
            .viol_o   (viol_q[g]),
            .tag_o    (tag_q[g]),
            .word_o   (word_q[g])
        );
    end

    // round-robin victim pointer: moves only on a full-table replacement
    always_ff @(posedge clk) begin
        if (rst)
            rr_ptr_q <= '0;
        else if (ins_valid && (alloc_kind == SLOT_EVICT))
            rr_ptr_q <= IDX_W'(rr_next(int'(rr_ptr_q), ENTRIES));
    end

    // check result, registered one cycle after the request
    always_ff @(posedge clk) begin
        if (rst) begin
            resp_q <= '0;
        end else begin
            resp_q.done   <= chk_valid;
            resp_q.replay <= chk_valid && (!hit || hit_viol);
        end
    end

    assign chk_done   = resp_q.done;
    assign chk_replay = resp_q.replay;
endmodule

// File: rtl/sltrk_checker.sv
module sltrk_checker #(
    parameter int ENTRIES    = 8,
    parameter int TAG_W      = 5,
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              ins_valid,
    input logic [TAG_W-1:0]  ins_tag,
    input logic [ADDR_W-1:0] ins_addr,
    input logic              st_valid,
    input logic [ADDR_W-1:0] st_addr,
    input logic              chk_valid,
    input logic [TAG_W-1:0]  chk_tag,
    input logic              chk_done,
    input logic              chk_replay,
    input logic [ENTRIES-1:0] hit_vec
);
    localparam int OW = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 0;

    // R2: a request is answered in the next cycle
    assert_resp_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
        chk_valid |=> chk_done);

    // R2: no answer without a request one cycle earlier
    assert_no_spurious_done_R2: assert property (@(posedge clk) disable iff (rst)
        chk_done |-> $past(chk_valid));

    // R2: replay only alongside a valid answer
    assert_replay_needs_done_R2: assert property (@(posedge clk) disable iff (rst)
        chk_replay |-> chk_done);

    // R3, R9: an entry inserted last cycle is clean, even with a store to it then
    assert_fresh_entry_clean_R9: assert property (@(posedge clk) disable iff (rst)
        (chk_valid && $past(ins_valid) && ($past(ins_tag) == chk_tag)) |=> !chk_replay);

    // R6: a check right after a check of the same tag finds nothing
    assert_consumed_entry_R6: assert property (@(posedge clk) disable iff (rst)
        (chk_valid && $past(chk_valid) && ($past(chk_tag) == chk_tag)
         && !($past(ins_valid) && ($past(ins_tag) == chk_tag))) |=> chk_replay);

    // R4: a same-word store after the insert forces a replay
    assert_store_marks_R4: assert property (@(posedge clk) disable iff (rst)
        (chk_valid && $past(ins_valid, 2) && ($past(ins_tag, 2) == chk_tag)
         && $past(st_valid)
         && ($past(st_addr[ADDR_W-1:OW]) == $past(ins_addr[ADDR_W-1:OW], 2))
         && !($past(ins_valid) && ($past(ins_tag) == chk_tag))) |=> chk_replay);

    // R10: tags stay unique in the table
    assert_unique_tag_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));
endmodule

bind spec_load_tracker sltrk_checker #(
    .ENTRIES(ENTRIES), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)
) u_sltrk_checker (
    .clk        (clk),
    .rst        (rst),
    .ins_valid  (ins_valid),
    .ins_tag    (ins_tag),
    .ins_addr   (ins_addr),
    .st_valid   (st_valid),
    .st_addr    (st_addr),
    .chk_valid  (chk_valid),
    .chk_tag    (chk_tag),
    .chk_done   (chk_done),
    .chk_replay (chk_replay),
    .hit_vec    (hit_vec)
);

// File: tb/sim_spec_load_tracker.sv
`timescale 1ns/1ps
module sim_spec_load_tracker;
    localparam int E  = 8;
    localparam int TW = 5;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ins_valid = 1'b0, st_valid = 1'b0, chk_valid = 1'b0;
    logic [TW-1:0] ins_tag = '0, chk_tag = '0;
    logic [AW-1:0] ins_addr = '0, st_addr = '0;
    logic          chk_done, chk_replay;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference model of the table
    bit          mv [E];
    bit          mx [E];
    int          mt [E];
    int unsigned mw [E];
    int          mptr;

    always #10 clk = ~clk;   // 50 MHz

    spec_load_tracker #(.ENTRIES(E), .TAG_W(TW), .ADDR_W(AW), .WORD_BYTES(4)) u0 (
        .clk(clk), .rst(rst),
        .ins_valid(ins_valid), .ins_tag(ins_tag), .ins_addr(ins_addr),
        .st_valid(st_valid), .st_addr(st_addr),
        .chk_valid(chk_valid), .chk_tag(chk_tag),
        .chk_done(chk_done), .chk_replay(chk_replay)
    );

    task automatic check1(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < E; i++) begin
            mv[i] = 0; mx[i] = 0; mt[i] = 0; mw[i] = 0;
        end
        mptr = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        ins_valid = 0; st_valid = 0; chk_valid = 0;
        @(negedge clk);
        check1("R1 done low in reset", chk_done, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        model_clear();
        @(negedge clk);
        check1("R1 done low after reset", chk_done, 1'b0);
    endtask

    // one cycle: drive at negedge, expect at the following negedge
    task automatic step(input bit iv, input int itag, input int unsigned ia,
                        input bit sv, input int unsigned sa,
                        input bit cv, input int ctag, input string req);
        bit pv [E]; bit px [E]; int pt [E]; int unsigned pw [E];
        bit hit, exp_rep, tfound, ffound;
        int hidx, slot;
        ins_valid = iv; ins_tag = TW'(itag); ins_addr = ia;
        st_valid = sv;  st_addr = sa;
        chk_valid = cv; chk_tag = TW'(ctag);
        for (int i = 0; i < E; i++) begin
            pv[i] = mv[i]; px[i] = mx[i]; pt[i] = mt[i]; pw[i] = mw[i];
        end
        hit = 0; hidx = 0;
        for (int i = 0; i < E; i++)
            if (pv[i] && pt[i] == ctag) begin hit = 1; hidx = i; end
        exp_rep = !hit || px[hidx];
        if (cv && hit) mv[hidx] = 0;
        if (sv)
            for (int i = 0; i < E; i++)
                if (pv[i] && pw[i] == (sa >> 2)) mx[i] = 1;
        if (iv) begin
            tfound = 0; ffound = 0; slot = 0;
            for (int i = E - 1; i >= 0; i--)
                if (pv[i] && pt[i] == itag) begin tfound = 1; slot = i; end
            if (!tfound) begin
                for (int i = E - 1; i >= 0; i--)
                    if (!pv[i]) begin ffound = 1; slot = i; end
                if (!ffound) begin
                    slot = mptr;
                    mptr = (mptr + 1) % E;
                end
            end
            mv[slot] = 1; mx[slot] = 0; mt[slot] = itag; mw[slot] = ia >> 2;
        end
        @(posedge clk);
        @(negedge clk);
        ins_valid = 0; st_valid = 0; chk_valid = 0;
        check1({req, " R2 done"}, chk_done, cv);
        if (cv) check1({req, " replay"}, chk_replay, exp_rep);
        else    check1({req, " R2 replay idle"}, chk_replay, 1'b0);
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, "idle");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        model_clear();
        do_reset();

        // R1 / R7: empty table replays
        step(0, 0, 0, 0, 0, 1, 3, "R1 R7 empty check");
        // R3: clean load kept
        step(1, 1, 32'h100, 0, 0, 0, 0, "R3 insert");
        idle();
        step(0, 0, 0, 0, 0, 1, 1, "R3 clean check");
        // R4: same word, other byte offset
        step(1, 2, 32'h200, 0, 0, 0, 0, "R4 insert");
        step(0, 0, 0, 1, 32'h203, 0, 0, "R4 store");
        step(0, 0, 0, 0, 0, 1, 2, "R4 conflict check");
        // R5: neighbouring word ignored
        step(1, 3, 32'h300, 0, 0, 0, 0, "R5 insert");
        step(0, 0, 0, 1, 32'h304, 0, 0, "R5 store");
        step(0, 0, 0, 0, 0, 1, 3, "R5 unaffected check");
        // R6: consumed entry
        step(0, 0, 0, 0, 0, 1, 3, "R6 second check");
        // R9: insert and store together
        step(1, 4, 32'h400, 1, 32'h401, 0, 0, "R9 insert+store");
        step(0, 0, 0, 0, 0, 1, 4, "R9 check");
        // R10: re-insert moves address and clears flag
        step(1, 5, 32'h500, 0, 0, 0, 0, "R10 insert");
        step(0, 0, 0, 1, 32'h600, 0, 0, "R10 store old");
        step(1, 5, 32'h600, 0, 0, 0, 0, "R10 reinsert");
        step(0, 0, 0, 1, 32'h500, 0, 0, "R10 store other");
        step(0, 0, 0, 0, 0, 1, 5, "R10 check");
        // R11: check reads state before same-cycle store/insert
        step(1, 6, 32'h700, 0, 0, 0, 0, "R11 insert");
        step(0, 0, 0, 1, 32'h700, 1, 6, "R11 check with store");
        step(1, 7, 32'h800, 0, 0, 0, 0, "R11 insert b");
        step(0, 0, 0, 1, 32'h802, 0, 0, "R11 store b");
        step(1, 7, 32'h900, 0, 0, 1, 7, "R11 check with reinsert");
        step(0, 0, 0, 0, 0, 1, 7, "R11 fresh entry survives");
        // R12: one store marks two entries
        step(1, 8, 32'hA00, 0, 0, 0, 0, "R12 insert a");
        step(1, 9, 32'hA02, 0, 0, 0, 0, "R12 insert b");
        step(0, 0, 0, 1, 32'hA01, 0, 0, "R12 store");
        step(0, 0, 0, 0, 0, 1, 8, "R12 check a");
        step(0, 0, 0, 0, 0, 1, 9, "R12 check b");

        // R8: fill, evict, free-first, pointer advance
        do_reset();
        for (int k = 0; k < E; k++)
            step(1, 10 + k, 32'h1000 + 32'(k * 16), 0, 0, 0, 0, "R8 fill");
        step(1, 18, 32'h2000, 0, 0, 0, 0, "R8 evict slot0");
        step(0, 0, 0, 0, 0, 1, 11, "R8 survivor check");
        step(0, 0, 0, 0, 0, 1, 10, "R8 evicted check");
        step(1, 19, 32'h2100, 0, 0, 0, 0, "R8 free slot fill");
        step(1, 20, 32'h2200, 0, 0, 0, 0, "R8 evict slot1");
        step(0, 0, 0, 0, 0, 1, 19, "R8 second evicted check");
        step(0, 0, 0, 0, 0, 1, 12, "R8 untouched check");

        // random traffic: R3 R4 R5 R6 R7 R8 R9 R10 R11 R12
        seed = 32'd1234;
        void'($urandom(seed));
        for (int n = 0; n < 3000; n++) begin
            int unsigned r;
            r = $urandom;
            step(r[0] | r[1], int'($urandom % 12), 32'h4000 + (($urandom % 16) << 2) + ($urandom % 4),
                 r[2] & r[3], 32'h4000 + (($urandom % 16) << 2) + ($urandom % 4),
                 r[4], int'($urandom % 12), "random R4 R8 R10");
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule